// File: doc/BRIEF.md
# Multirate Data-Strobe Serial Port

This block sits between a link layer and one cable port that signals with a data line and a strobe line. On the transmit side it takes one byte at a time from the link layer on system-clock cycles and shifts it out most-significant bit first, at one of three line rates. It drives the encoded data on line pair B and the strobe on line pair A. The strobe changes only when the data bit equals the previous one, so each bit period changes exactly one of the two lines.

On the receive side the roles of the pairs swap: data arrives on pair A and strobe on pair B. The block decodes one bit for every change of the exclusive-OR of the two lines, packs the bits into bytes, and passes them through a small Gray-pointer buffer into the system-clock domain. A sticky flag records a byte that was lost because the buffer was full. The received line levels are also copied out to a second port when that port is active.

The whole block runs on the fast reference clock. The system clock is an enable input (`sys_ce`) that pulses once every eighth reference cycle. The full line rate is one bit per reference cycle.

Top module: `ds_serial_port`

## Requirements
- R1: After reset every line output, output enable, `tx_ready`, `rx_valid`, `rx_ovf` and `rpt_oe` is 0. The transmit line state starts with data=0 and strobe=0.
- R2: A byte on `tx_data` is taken on a reference cycle with `sys_ce`=1 when `tx_valid`=1, `rx_mode`=0, the holding register is empty, and no packet-closing byte is still pending. `tx_ready` is 1 for the one cycle that follows each take.
- R3: Transmitted bits leave most-significant bit first. Data is on `line_b_out` and strobe is on `line_a_out`, and all bytes of a packet are sent back to back.
- R4: For every transmitted bit exactly one line changes. The strobe toggles when the new data bit equals the previous data bit, and it holds otherwise.
- R5: `spd_sel` selects the bit period: 0 gives 4 reference cycles, 1 gives 2, and 2 or 3 give 1.
- R6: The rate is sampled when the first byte of a packet is taken. It holds until the last bit of the byte marked by `tx_last` has been sent, whatever `spd_sel` does in between.
- R7: While `rx_mode`=1 no byte is taken. `line_a_oe` and `line_b_oe` are 0 from the cycle after `rx_mode` rises.
- R8: With `rx_mode`=1 a bit is decoded on each change of `line_a_in` XOR `line_b_in`, and its value is the level of `line_a_in`. Each group of 8 bits is delivered MSB first as one `rx_data` byte with a one-cycle `rx_valid`.
- R9: `rx_valid` rises only in the cycle after a cycle with `sys_ce`=1. At most one byte is delivered per `sys_ce`.
- R10: The receive buffer holds 4 bytes. A byte completed while the buffer is full is dropped and sets `rx_ovf`, which stays 1 until reset. Bytes already buffered are still delivered in order.
- R11: `rpt_oe` is 1 exactly when `rx_mode` and `rpt_en` were both 1 in the previous cycle. `rpt_b_out` copies the received data level and `rpt_a_out` copies the received strobe level, with a fixed delay, so the repeated stream decodes to the same bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock (one full-rate bit period) |
| rst | input | 1 | Synchronous active-high reset |
| sys_ce | input | 1 | System-clock enable, one pulse per system cycle |
| spd_sel | input | 2 | Line rate request: 0 quarter, 1 half, 2/3 full |
| tx_valid | input | 1 | Link layer offers a byte |
| tx_data | input | 8 | Byte to send |
| tx_last | input | 1 | Offered byte closes the packet |
| tx_ready | output | 1 | Pulse: offered byte was taken |
| rx_mode | input | 1 | Port is receiving; transmitters off |
| line_a_in | input | 1 | Received data level (pair A) |
| line_b_in | input | 1 | Received strobe level (pair B) |
| line_a_out | output | 1 | Transmitted strobe (pair A) |
| line_b_out | output | 1 | Transmitted data (pair B) |
| line_a_oe | output | 1 | Pair A driver enable |
| line_b_oe | output | 1 | Pair B driver enable |
| rx_valid | output | 1 | Pulse: `rx_data` holds a received byte |
| rx_data | output | 8 | Received byte |
| rx_ovf | output | 1 | Sticky receive buffer overflow |
| rpt_en | input | 1 | Second port is connected and active |
| rpt_a_out | output | 1 | Repeated strobe toward second port |
| rpt_b_out | output | 1 | Repeated data toward second port |
| rpt_oe | output | 1 | Second-port driver enable |

## Verification
A byte can finish in the receive decoder and enter the buffer in the same reference cycle that a `sys_ce` pulse pops the buffer. The bench provokes this with a six-byte stream at one bit per reference cycle, so byte completions and pops both recur every eight cycles and line up. It judges the result by requiring every byte to arrive once, in order, with `rx_ovf` still 0. A second case holds `sys_ce` low during the stream so that writes meet a full buffer. Only the four oldest bytes may then come out.

// File: rtl/ds_pkg.sv
package ds_pkg;

  // Line-rate request codes.
  typedef enum logic [1:0] {
    SPD_R1X  = 2'd0,  // one bit every 4 reference cycles
    SPD_R2X  = 2'd1,  // one bit every 2 reference cycles
    SPD_R4X  = 2'd2,  // one bit every reference cycle
    SPD_R4XB = 2'd3   // alias of full rate
  } spd_e;

  // Mask applied to the free-running 2-bit reference divider; a bit slot
  // opens when all masked bits are set.
  function automatic logic [1:0] spd_mask(input logic [1:0] spd);
    case (spd_e'(spd))
      SPD_R1X: return 2'b11;
      SPD_R2X: return 2'b01;
      default: return 2'b00;
    endcase
  endfunction

endpackage

// File: rtl/ds_tx.sv
module ds_tx
  import ds_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         sys_ce,
  input  logic         rx_mode,
  input  logic [1:0]   spd_sel,
  input  logic         tx_valid,
  input  logic [W-1:0] tx_data,
  input  logic         tx_last,
  output logic         tx_ready,
  output logic         d_out,
  output logic         s_out,
  output logic         oe,
  output logic [1:0]   spd_q
);

  localparam int CW = $clog2(W + 1);

  logic [1:0]    ref_cnt;
  logic [1:0]    spd_r;
  logic [1:0]    mask;
  logic [W-1:0]  hold_q;
  logic          hold_last;
  logic          hold_full;
  logic          eop_seen;
  logic          in_pkt;
  logic [W-1:0]  sh_q;
  logic          sh_last;
  logic [CW-1:0] sh_cnt;
  logic          d_q, s_q, oe_q, ready_q;

  logic bit_ce, take, load, shift, emit, nbit, end_pkt;

  always_comb begin
    mask    = spd_mask(spd_r);
    bit_ce  = (ref_cnt & mask) == mask;
    take    = sys_ce && tx_valid && !hold_full && !eop_seen && !rx_mode;
    load    = bit_ce && (sh_cnt == '0) && hold_full;
    shift   = bit_ce && (sh_cnt != '0);
    emit    = load || shift;
    nbit    = load ? hold_q[W-1] : sh_q[W-1];
    end_pkt = shift && (sh_cnt == CW'(1)) && sh_last;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ref_cnt   <= '0;
      spd_r     <= '0;
      hold_q    <= '0;
      hold_last <= 1'b0;
      hold_full <= 1'b0;
      eop_seen  <= 1'b0;
      in_pkt    <= 1'b0;
      sh_q      <= '0;
      sh_last   <= 1'b0;
      sh_cnt    <= '0;
      d_q       <= 1'b0;
      s_q       <= 1'b0;
      oe_q      <= 1'b0;
      ready_q   <= 1'b0;
    end else begin
      ref_cnt <= ref_cnt + 2'd1;
      ready_q <= take;
      oe_q    <= in_pkt && !rx_mode;

      if (take) begin
        hold_q    <= tx_data;
        hold_last <= tx_last;
        hold_full <= 1'b1;
        if (tx_last) eop_seen <= 1'b1;
        if (!in_pkt) begin
          in_pkt <= 1'b1;
          spd_r  <= spd_sel;   // rate frozen for the packet
        end
      end

      if (load) begin
        hold_full <= 1'b0;
        sh_q      <= hold_q << 1;
        sh_cnt    <= CW'(W - 1);
        sh_last   <= hold_last;
      end

      if (shift) begin
        sh_q   <= sh_q << 1;
        sh_cnt <= sh_cnt - CW'(1);
      end

      if (emit) begin
        d_q <= nbit;
        if (nbit == d_q) s_q <= ~s_q;
      end

      if (end_pkt) begin
        in_pkt   <= 1'b0;
        eop_seen <= 1'b0;
      end
    end
  end

  assign tx_ready = ready_q;
  assign d_out    = d_q;
  assign s_out    = s_q;
  assign oe       = oe_q;
  assign spd_q    = spd_r;

endmodule

// File: rtl/ds_rx_decode.sv
module ds_rx_decode #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         rx_mode,
  input  logic         d_in,
  input  logic         s_in,
  output logic         byte_we,
  output logic [W-1:0] byte_q,
  output logic         rpt_d,
  output logic         rpt_s
);

  localparam int CW = $clog2(W);

  logic          d1, s1, d2, s2, par_q;
  logic [W-1:0]  sh;
  logic [CW-1:0] cnt;
  logic          we_q;
  logic [W-1:0]  byte_r;
  logic          rd_q, rs_q;

  logic          par, bit_ev;
  logic [W-1:0]  sh_next;

  always_comb begin
    par     = d2 ^ s2;
    bit_ev  = rx_mode && (par != par_q);
    sh_next = (sh << 1) | W'(d2);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      d1 <= 1'b0; s1 <= 1'b0; d2 <= 1'b0; s2 <= 1'b0;
      par_q  <= 1'b0;
      sh     <= '0;
      cnt    <= '0;
      we_q   <= 1'b0;
      byte_r <= '0;
      rd_q   <= 1'b0;
      rs_q   <= 1'b0;
    end else begin
      d1 <= d_in;  s1 <= s_in;
      d2 <= d1;    s2 <= s1;
      par_q <= par;
      rd_q  <= d2;
      rs_q  <= s2;
      we_q  <= 1'b0;
      if (!rx_mode) begin
        cnt <= '0;
      end else if (bit_ev) begin
        sh <= sh_next;
        if (cnt == CW'(W - 1)) begin
          byte_r <= sh_next;
          we_q   <= 1'b1;
          cnt    <= '0;
        end else begin
          cnt <= cnt + CW'(1);
        end
      end
    end
  end

  assign byte_we = we_q;
  assign byte_q  = byte_r;
  assign rpt_d   = rd_q;
  assign rpt_s   = rs_q;

endmodule

// File: rtl/ds_gray_fifo.sv
module ds_gray_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic         wclk,
  input  logic         rclk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         rd_ce,
  output logic         rd_valid,
  output logic [W-1:0] rd_data,
  output logic         ovf
);

  localparam int AW = $clog2(DEPTH);

  function automatic logic [AW:0] b2g(input logic [AW:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [AW:0] g2b(input logic [AW:0] g);
    logic [AW:0] b;
    b[AW] = g[AW];
    for (int i = AW - 1; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [W-1:0] mem [DEPTH];

  logic [AW:0] wbin, wgray, rg_s1, rg_s2;
  logic [AW:0] rbin, rgray, wg_s1, wg_s2;
  logic [AW:0] rs_bin;
  logic        full, empty, ovf_q, rv_q;

  always_comb begin
    rs_bin = g2b(rg_s2);
    full   = (wbin[AW] != rs_bin[AW]) && (wbin[AW-1:0] == rs_bin[AW-1:0]);
    empty  = (rgray == wg_s2);
  end

  // write domain
  always_ff @(posedge wclk) begin
    if (wr_en && !full) mem[wbin[AW-1:0]] <= wr_data;
  end

  always_ff @(posedge wclk) begin
    if (rst) begin
      wbin  <= '0;
      wgray <= '0;
      rg_s1 <= '0;
      rg_s2 <= '0;
      ovf_q <= 1'b0;
    end else begin
      rg_s1 <= rgray;
      rg_s2 <= rg_s1;
      if (wr_en) begin
        if (!full) begin
          wbin  <= wbin + 1'b1;
          wgray <= b2g(wbin + 1'b1);
        end else begin
          ovf_q <= 1'b1;
        end
      end
    end
  end

  // read domain
  always_ff @(posedge rclk) begin
    if (rd_ce && !empty) rd_data <= mem[rbin[AW-1:0]];
  end

  always_ff @(posedge rclk) begin
    if (rst) begin
      rbin  <= '0;
      rgray <= '0;
      wg_s1 <= '0;
      wg_s2 <= '0;
      rv_q  <= 1'b0;
    end else begin
      wg_s1 <= wgray;
      wg_s2 <= wg_s1;
      rv_q  <= rd_ce && !empty;
      if (rd_ce && !empty) begin
        rbin  <= rbin + 1'b1;
        rgray <= b2g(rbin + 1'b1);
      end
    end
  end

  assign rd_valid = rv_q;
  assign ovf      = ovf_q;

endmodule

// File: rtl/ds_serial_port.sv
module ds_serial_port #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         sys_ce,
  input  logic [1:0]   spd_sel,
  input  logic         tx_valid,
  input  logic [W-1:0] tx_data,
  input  logic         tx_last,
  output logic         tx_ready,
  input  logic         rx_mode,
  input  logic         line_a_in,
  input  logic         line_b_in,
  output logic         line_a_out,
  output logic         line_b_out,
  output logic         line_a_oe,
  output logic         line_b_oe,
  output logic         rx_valid,
  output logic [W-1:0] rx_data,
  output logic         rx_ovf,
  input  logic         rpt_en,
  output logic         rpt_a_out,
  output logic         rpt_b_out,
  output logic         rpt_oe
);

  logic         tx_d, tx_s, tx_oe;
  logic [1:0]   spd_act;
  logic         dec_we;
  logic [W-1:0] dec_byte;
  logic         dec_rd, dec_rs;
  logic         rpt_oe_q;

  ds_tx #(.W(W)) u_tx (
    .clk      (clk),
    .rst      (rst),
    .sys_ce   (sys_ce),
    .rx_mode  (rx_mode),
    .spd_sel  (spd_sel),
    .tx_valid (tx_valid),
    .tx_data  (tx_data),
    .tx_last  (tx_last),
    .tx_ready (tx_ready),
    .d_out    (tx_d),
    .s_out    (tx_s),
    .oe       (tx_oe),
    .spd_q    (spd_act)
  );

  // receive: data on pair A, strobe on pair B
  ds_rx_decode #(.W(W)) u_dec (
    .clk     (clk),
    .rst     (rst),
    .rx_mode (rx_mode),
    .d_in    (line_a_in),
    .s_in    (line_b_in),
    .byte_we (dec_we),
    .byte_q  (dec_byte),
    .rpt_d   (dec_rd),
    .rpt_s   (dec_rs)
  );

  ds_gray_fifo #(.W(W), .DEPTH(DEPTH)) u_fifo (
    .wclk     (clk),
    .rclk     (clk),
    .rst      (rst),
    .wr_en    (dec_we),
    .wr_data  (dec_byte),
    .rd_ce    (sys_ce),
    .rd_valid (rx_valid),
    .rd_data  (rx_data),
    .ovf      (rx_ovf)
  );

  always_ff @(posedge clk) begin
    if (rst) rpt_oe_q <= 1'b0;
    else     rpt_oe_q <= rx_mode && rpt_en;
  end

  // transmit: data on pair B, strobe on pair A
  assign line_b_out = tx_d;
  assign line_a_out = tx_s;
  assign line_a_oe  = tx_oe;
  assign line_b_oe  = tx_oe;
  assign rpt_b_out  = dec_rd;
  assign rpt_a_out  = dec_rs;
  assign rpt_oe     = rpt_oe_q;

endmodule

// File: rtl/ds_serial_port_chk.sv
module ds_serial_port_chk (
  input logic       clk,
  input logic       rst,
  input logic       sys_ce,
  input logic       rx_mode,
  input logic       tx_ready,
  input logic       line_a_out,
  input logic       line_b_out,
  input logic       line_a_oe,
  input logic       line_b_oe,
  input logic       rx_valid,
  input logic       rx_ovf,
  input logic       rpt_en,
  input logic       rpt_oe,
  input logic [1:0] spd_q
);

  a_r2_ready_on_ce: assert property (@(posedge clk) disable iff (rst)
    tx_ready |-> $past(sys_ce));

  a_r4_one_line_moves: assert property (@(posedge clk) disable iff (rst)
    !$stable(line_b_out) |-> $stable(line_a_out));

  a_r6_rate_frozen: assert property (@(posedge clk) disable iff (rst)
    (line_b_oe && $past(line_b_oe)) |-> $stable(spd_q));

  a_r7_drivers_off: assert property (@(posedge clk) disable iff (rst)
    rx_mode |=> (!line_a_oe && !line_b_oe));

  a_r9_valid_after_ce: assert property (@(posedge clk) disable iff (rst)
    rx_valid |-> $past(sys_ce));

  a_r10_ovf_sticky: assert property (@(posedge clk) disable iff (rst)
    rx_ovf |=> rx_ovf);

  a_r11_rpt_off: assert property (@(posedge clk) disable iff (rst)
    !rpt_en |=> !rpt_oe);

endmodule

bind ds_serial_port ds_serial_port_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .sys_ce     (sys_ce),
  .rx_mode    (rx_mode),
  .tx_ready   (tx_ready),
  .line_a_out (line_a_out),
  .line_b_out (line_b_out),
  .line_a_oe  (line_a_oe),
  .line_b_oe  (line_b_oe),
  .rx_valid   (rx_valid),
  .rx_ovf     (rx_ovf),
  .rpt_en     (rpt_en),
  .rpt_oe     (rpt_oe),
  .spd_q      (spd_act)
);

// File: tb/ds_serial_port_bench.sv
`timescale 1ns/1ps
module ds_serial_port_bench;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       sys_ce = 1'b0;
  logic [1:0] spd_sel = 2'd0;
  logic       tx_valid = 1'b0;
  logic [7:0] tx_data = 8'h00;
  logic       tx_last = 1'b0;
  logic       tx_ready;
  logic       rx_mode = 1'b0;
  logic       line_a_in = 1'b0;
  logic       line_b_in = 1'b0;
  logic       line_a_out, line_b_out, line_a_oe, line_b_oe;
  logic       rx_valid;
  logic [7:0] rx_data;
  logic       rx_ovf;
  logic       rpt_en = 1'b0;
  logic       rpt_a_out, rpt_b_out, rpt_oe;

  always #4 clk = ~clk;  // 125 MHz

  ds_serial_port u_ds_serial_port (
    .clk(clk), .rst(rst), .sys_ce(sys_ce), .spd_sel(spd_sel),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_last(tx_last), .tx_ready(tx_ready),
    .rx_mode(rx_mode), .line_a_in(line_a_in), .line_b_in(line_b_in),
    .line_a_out(line_a_out), .line_b_out(line_b_out),
    .line_a_oe(line_a_oe), .line_b_oe(line_b_oe),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_ovf(rx_ovf),
    .rpt_en(rpt_en), .rpt_a_out(rpt_a_out), .rpt_b_out(rpt_b_out), .rpt_oe(rpt_oe)
  );

  int checks = 0;
  int errors = 0;

  // monitor state
  int   cyc = 0, sc = 0;
  bit   sys_run = 1'b0;
  logic pa = 1'b0, pb = 1'b0, pra = 1'b0, prb = 1'b0;
  logic tb_bits [64];
  int   tb_time [64];
  int   tb_n = 0, dual_err = 0, ready_n = 0, oe_seen = 0, ce_err = 0;
  logic [7:0] rx_got [16];
  int   rx_n = 0;
  logic rp_bits [128];
  int   rp_n = 0;

  // {spd[21:20], b0[19:12], b1[11:4], gap[3:0]}
  localparam logic [21:0] TXV [4] = '{
    {2'd2, 8'hA5, 8'h3C, 4'd1},
    {2'd1, 8'h00, 8'hFF, 4'd2},
    {2'd0, 8'h81, 8'h7E, 4'd4},
    {2'd3, 8'hFF, 8'hFF, 4'd1}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (!rst) begin
      if ((line_a_out != pa) && (line_b_out != pb)) dual_err++;
      if (((line_a_out ^ line_b_out) != (pa ^ pb)) && line_b_oe && tb_n < 64) begin
        tb_bits[tb_n] = line_b_out;
        tb_time[tb_n] = cyc;
        tb_n++;
      end
      if (line_b_oe) oe_seen++;
      if (tx_ready) ready_n++;
      if (((rpt_a_out ^ rpt_b_out) != (pra ^ prb)) && rpt_oe && rp_n < 128) begin
        rp_bits[rp_n] = rpt_b_out;
        rp_n++;
      end
      if (rx_valid) begin
        if (!sys_ce) ce_err++;
        if (rx_n < 16) rx_got[rx_n] = rx_data;
        rx_n++;
      end
    end
    pa = line_a_out; pb = line_b_out; pra = rpt_a_out; prb = rpt_b_out;
    if (sys_run) begin
      sc++;
      sys_ce = (sc % 8 == 0);
    end else begin
      sys_ce = 1'b0;
    end
  end

  task automatic send_pkt(input logic [1:0] spd, input logic [7:0] b0, input logic [7:0] b1,
                          input bit chg, input logic [1:0] spd2);
    @(negedge clk);
    spd_sel = spd; tx_valid = 1'b1; tx_data = b0; tx_last = 1'b0;
    do @(negedge clk); while (!tx_ready);
    if (chg) spd_sel = spd2;
    tx_data = b1; tx_last = 1'b1;
    do @(negedge clk); while (!tx_ready);
    tx_valid = 1'b0; tx_last = 1'b0;
    while (line_b_oe) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  task automatic judge_pkt(input logic [7:0] b0, input logic [7:0] b1, input int gap,
                           input string tag);
    int bad = 0, sp = 0;
    chk(tb_n == 16, {tag, " R3 bit count"}, tb_n, 16);
    for (int i = 0; i < 16 && i < tb_n; i++) begin
      logic e;
      e = (i < 8) ? b0[7 - i] : b1[15 - i];
      if (tb_bits[i] !== e) bad++;
    end
    chk(bad == 0, {tag, " R3 bit values MSB first"}, bad, 0);
    for (int i = 1; i < tb_n; i++)
      if (tb_time[i] - tb_time[i-1] != gap) sp++;
    chk(sp == 0, {tag, " R5 bit spacing"}, sp, 0);
    chk(dual_err == 0, {tag, " R4 one line per bit"}, dual_err, 0);
  endtask

  logic ld = 1'b0, ls = 1'b0;

  task automatic rx_byte(input logic [7:0] b, input int per);
    for (int i = 7; i >= 0; i--) begin
      @(negedge clk);
      if (b[i] == ld) ls = ~ls;
      ld = b[i];
      line_a_in = ld; line_b_in = ls;
      repeat (per - 1) @(negedge clk);
    end
  endtask

  logic [7:0] rxv [6] = '{8'h96, 8'h00, 8'hFF, 8'h5A, 8'hE1, 8'h3C};

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    sys_run = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk({line_a_out, line_b_out, line_a_oe, line_b_oe, tx_ready, rx_valid, rx_ovf, rpt_oe} == 8'h00,
        "R1 reset outputs", {line_a_out, line_b_out, line_a_oe, line_b_oe, tx_ready, rx_valid, rx_ovf, rpt_oe}, 0);

    // R6: rate change mid-packet ignored (quarter rate held)
    tb_n = 0; ready_n = 0;
    send_pkt(2'd0, 8'hC3, 8'h5A, 1'b1, 2'd2);
    judge_pkt(8'hC3, 8'h5A, 4, "R6 held rate");
    chk(ready_n == 2, "R2 tx_ready pulses", ready_n, 2);

    // table walk (R3, R4, R5)
    foreach (TXV[k]) begin
      tb_n = 0;
      send_pkt(TXV[k][21:20], TXV[k][19:12], TXV[k][11:4], 1'b0, 2'd0);
      judge_pkt(TXV[k][19:12], TXV[k][11:4], int'(TXV[k][3:0]), "table");
    end

    // R7: receive mode blocks transmit
    rx_mode = 1'b1;
    repeat (2) @(negedge clk);
    ready_n = 0; oe_seen = 0;
    tx_valid = 1'b1; tx_data = 8'h55; tx_last = 1'b1;
    repeat (40) @(negedge clk);
    tx_valid = 1'b0; tx_last = 1'b0;
    chk(ready_n == 0, "R7 no take in rx_mode", ready_n, 0);
    chk(oe_seen == 0, "R7 drivers off", oe_seen, 0);

    // R8/R11 + concurrent write/pop at full rate
    rpt_en = 1'b1;
    repeat (3) @(negedge clk);
    rx_n = 0; rp_n = 0; ce_err = 0;
    foreach (rxv[k]) rx_byte(rxv[k], 1);
    repeat (60) @(negedge clk);
    chk(rx_n == 6, "R8 byte count full rate", rx_n, 6);
    for (int k = 0; k < 6 && k < rx_n; k++)
      chk(rx_got[k] == rxv[k], "R8 byte value", rx_got[k], rxv[k]);
    chk(rx_ovf == 1'b0, "R10 no overflow at matched rate", rx_ovf, 0);
    chk(ce_err == 0, "R9 delivery follows sys_ce", ce_err, 0);
    begin
      int bad = 0;
      for (int i = 0; i < 48 && i < rp_n; i++)
        if (rp_bits[i] !== rxv[i / 8][7 - (i % 8)]) bad++;
      chk(rp_n == 48, "R11 repeated bit count", rp_n, 48);
      chk(bad == 0, "R11 repeated bit values", bad, 0);
    end

    // R11 repeat disabled, quarter-rate receive
    rpt_en = 1'b0;
    repeat (3) @(negedge clk);
    rx_n = 0; rp_n = 0;
    rx_byte(8'hA7, 4);
    rx_byte(8'h18, 4);
    repeat (40) @(negedge clk);
    chk(rx_n == 2 && rx_got[0] == 8'hA7 && rx_got[1] == 8'h18, "R8 quarter-rate bytes",
        rx_n, 2);
    chk(rp_n == 0 && rpt_oe == 1'b0, "R11 repeat off", rp_n, 0);

    // R10 overflow: stall pops
    sys_run = 1'b0;
    repeat (4) @(negedge clk);
    rx_n = 0;
    foreach (rxv[k]) rx_byte(rxv[k], 1);
    repeat (30) @(negedge clk);
    chk(rx_ovf == 1'b1, "R10 overflow flagged", rx_ovf, 1);
    chk(rx_n == 0, "R9 nothing without sys_ce", rx_n, 0);
    sys_run = 1'b1;
    repeat (80) @(negedge clk);
    chk(rx_n == 4, "R10 buffered bytes delivered", rx_n, 4);
    for (int k = 0; k < 4 && k < rx_n; k++)
      chk(rx_got[k] == rxv[k], "R10 buffered order", rx_got[k], rxv[k]);
    chk(rx_ovf == 1'b1, "R10 flag sticky", rx_ovf, 1);

    // R1: reset clears sticky flag
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(rx_ovf == 1'b0 && rx_valid == 1'b0 && line_a_oe == 1'b0, "R1 reset clears", rx_ovf, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog all-R act=timeout exp=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule